// File: doc/BRIEF.md
# Configurable DDR Input Capture Path

This block takes one single-ended serial input and brings it into the core clock domain. A static mode setting picks one of four capture schemes. Bypass is a plain wire. Single-register mode captures on one clock edge. Full-rate DDR mode samples both edges of the fast clock and presents them as a two-bit word. Half-rate mode gathers two of those words into a four-bit word clocked by a second clock at half the rate. In that last mode the bus is four times wider and updates four times less often than the serial stream, so the throughput stays the same.

Two clocks drive the block. The full-rate clock runs at exactly twice the frequency of the half-rate clock, and every rising edge of the half-rate clock coincides with a rising edge of the full-rate clock. An asynchronous clear and an asynchronous preset act on every capture register at once. The mode may only be changed while clear is held. Lanes that the current mode does not use read as zero.

Top module: `ddr_capture_path`

## Requirements
- R1: With mode 0 (bypass), dout[0] equals pad_in combinationally, with no register in the path, and dout[3:1] is 0.
- R2: With mode 1 (single register), dout[0] holds the pad value captured at the most recent rising edge of clk_fr, and dout[3:1] is 0.
- R3: With mode 2 (full-rate DDR), label the samples taken at rising edge k as R[k] and at the falling edge that follows as F[k]. After rising edge k, dout[0] = R[k-1] and dout[1] = F[k-1], so both bits are aligned to the rising edge. dout[3:2] is 0.
- R4: With mode 3 (half-rate), dout is loaded only at rising edges of clk_hr. At the coincident clk_fr rising edge k, dout becomes {F[k-2], R[k-2], F[k-3], R[k-3]}, with bit 0 the oldest sample and bit 3 the newest. dout then holds for two clk_fr periods.
- R5: While aclr is high, every capture register is 0, so dout is 0 in modes 1 to 3, with or without clock edges.
- R6: While apre is high and aclr is low, every capture register is 1, so dout shows ones on the lanes of the mode: 4'h1 in mode 1, 4'h3 in mode 2 and 4'hF in mode 3.
- R7: When aclr and apre are both high, clear wins and dout is 0 in modes 1 to 3.
- R8: The mode input is static. It changes only while aclr is high, and after clear is released dout follows the newly chosen mode.
- R9: In bypass mode, clear and preset have no effect on dout, which keeps following pad_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fr | input | 1 | Full-rate capture clock, sampled on both edges |
| clk_hr | input | 1 | Half-rate clock, rising edges aligned with clk_fr |
| aclr | input | 1 | Asynchronous clear of all capture registers, active high |
| apre | input | 1 | Asynchronous preset of all capture registers, active high |
| mode | input | 2 | 0 bypass, 1 single register, 2 full-rate DDR, 3 half-rate |
| pad_in | input | 1 | Serial data from the pin |
| dout | output | 4 | Captured data, lanes beyond the mode's width are 0 |

## Verification
An asynchronous clear can arrive in the very time step in which clk_hr rises together with clk_fr. At that moment the half-rate register would otherwise load a new four-bit word. The bench provokes this by raising aclr at a coincident rising edge while running in mode 3, and requires dout to read 0 three nanoseconds later. It also drives clear and preset together in every mode, to show that clear takes priority over preset while bypass ignores both. A behavioural history of the rising and falling samples judges every cycle once clear is released.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;

  typedef enum logic [1:0] {
    CAP_BYPASS = 2'd0,
    CAP_SINGLE = 2'd1,
    CAP_DDR    = 2'd2,
    CAP_HALF   = 2'd3
  } cap_mode_e;

  // Number of output lanes a mode drives, for a half-rate stage of `pairs` pairs.
  function automatic int unsigned live_lanes(input logic [1:0] m, input int unsigned pairs);
    case (m)
      2'd0:    return 1;
      2'd1:    return 1;
      2'd2:    return 2;
      default: return 2 * pairs;
    endcase
  endfunction

endpackage

// File: rtl/ddrcap_fr_stage.sv
// Full-rate stage: rising-edge capture, falling-edge capture, and realignment
// of both samples onto the rising edge.
module ddrcap_fr_stage (
  input  logic       clk_fr,
  input  logic       aclr,
  input  logic       apre,
  input  logic       pad_in,
  output logic       rise_bit,
  output logic [1:0] pair_out
);

  logic fall_bit;
  logic rise_al;
  logic fall_al;

  always_ff @(posedge clk_fr or posedge aclr or posedge apre) begin
    if (aclr)      rise_bit <= 1'b0;
    else if (apre) rise_bit <= 1'b1;
    else           rise_bit <= pad_in;
  end

  always_ff @(negedge clk_fr or posedge aclr or posedge apre) begin
    if (aclr)      fall_bit <= 1'b0;
    else if (apre) fall_bit <= 1'b1;
    else           fall_bit <= pad_in;
  end

  // Both bits re-registered on the rising edge so the pair leaves together.
  always_ff @(posedge clk_fr or posedge aclr or posedge apre) begin
    if (aclr) begin
      rise_al <= 1'b0;
      fall_al <= 1'b0;
    end else if (apre) begin
      rise_al <= 1'b1;
      fall_al <= 1'b1;
    end else begin
      rise_al <= rise_bit;
      fall_al <= fall_bit;
    end
  end

  assign pair_out = {fall_al, rise_al};

endmodule

// File: rtl/ddrcap_hr_stage.sv
// Half-rate stage: keeps PAIRS-1 older pairs in the fast domain and loads the
// widened word on the slow clock. Oldest pair sits in the low bits.
module ddrcap_hr_stage #(
  parameter int unsigned PAIRS = 2
) (
  input  logic                 clk_fr,
  input  logic                 clk_hr,
  input  logic                 aclr,
  input  logic                 apre,
  input  logic [1:0]           pair_in,
  output logic [2*PAIRS-1:0]   word_out
);

  localparam int unsigned OUT_W  = 2 * PAIRS;
  localparam int unsigned HIST_N = PAIRS - 1;

  logic [1:0]       hist [HIST_N];
  logic [OUT_W-1:0] word_nx;

  genvar g;
  for (g = 0; g < HIST_N; g++) begin : g_hist
    if (g == 0) begin : g_head
      always_ff @(posedge clk_fr or posedge aclr or posedge apre) begin
        if (aclr)      hist[g] <= 2'b00;
        else if (apre) hist[g] <= 2'b11;
        else           hist[g] <= pair_in;
      end
    end else begin : g_tail
      always_ff @(posedge clk_fr or posedge aclr or posedge apre) begin
        if (aclr)      hist[g] <= 2'b00;
        else if (apre) hist[g] <= 2'b11;
        else           hist[g] <= hist[g-1];
      end
    end
  end

  always_comb begin
    word_nx[OUT_W-1 -: 2] = pair_in;
    for (int i = 0; i < int'(HIST_N); i++) begin
      word_nx[2*(int'(HIST_N)-1-i) +: 2] = hist[i];
    end
  end

  always_ff @(posedge clk_hr or posedge aclr or posedge apre) begin
    if (aclr)      word_out <= '0;
    else if (apre) word_out <= '1;
    else           word_out <= word_nx;
  end

endmodule

// File: rtl/ddrcap_sel.sv
// Output selector: picks the source for the mode and zeroes unused lanes.
module ddrcap_sel #(
  parameter int unsigned PAIRS = 2
) (
  input  logic [1:0]         mode,
  input  logic               pad_in,
  input  logic               rise_bit,
  input  logic [1:0]         pair_in,
  input  logic [2*PAIRS-1:0] word_in,
  output logic [2*PAIRS-1:0] dout
);
  import ddrcap_pkg::*;

  localparam int unsigned OUT_W = 2 * PAIRS;

  logic [OUT_W-1:0] raw;
  logic [OUT_W-1:0] mask;

  always_comb begin
    raw = '0;
    unique case (cap_mode_e'(mode))
      CAP_BYPASS: raw[0]   = pad_in;
      CAP_SINGLE: raw[0]   = rise_bit;
      CAP_DDR:    raw[1:0] = pair_in;
      CAP_HALF:   raw      = word_in;
    endcase
    mask = OUT_W'((33'd1 << live_lanes(mode, PAIRS)) - 33'd1);
    dout = raw & mask;
  end

endmodule

// File: rtl/ddr_capture_path.sv
module ddr_capture_path #(
  parameter int unsigned PAIRS = 2
) (
  input  logic               clk_fr,
  input  logic               clk_hr,
  input  logic               aclr,
  input  logic               apre,
  input  logic [1:0]         mode,
  input  logic               pad_in,
  output logic [2*PAIRS-1:0] dout
);

  // Named internal events between the stages.
  logic                 fr_rise_bit;
  logic [1:0]           fr_pair;
  logic [2*PAIRS-1:0]   hr_word;

  ddrcap_fr_stage u_fr (
    .clk_fr   (clk_fr),
    .aclr     (aclr),
    .apre     (apre),
    .pad_in   (pad_in),
    .rise_bit (fr_rise_bit),
    .pair_out (fr_pair)
  );

  ddrcap_hr_stage #(.PAIRS(PAIRS)) u_hr (
    .clk_fr   (clk_fr),
    .clk_hr   (clk_hr),
    .aclr     (aclr),
    .apre     (apre),
    .pair_in  (fr_pair),
    .word_out (hr_word)
  );

  ddrcap_sel #(.PAIRS(PAIRS)) u_sel (
    .mode     (mode),
    .pad_in   (pad_in),
    .rise_bit (fr_rise_bit),
    .pair_in  (fr_pair),
    .word_in  (hr_word),
    .dout     (dout)
  );

endmodule

// File: rtl/ddrcap_chk.sv
module ddrcap_chk #(
  parameter int unsigned PAIRS = 2
) (
  input logic               clk_fr,
  input logic               clk_hr,
  input logic               aclr,
  input logic               apre,
  input logic [1:0]         mode,
  input logic               pad_in,
  input logic [2*PAIRS-1:0] dout
);
  import ddrcap_pkg::*;

  localparam int unsigned OUT_W = 2 * PAIRS;

  logic [2:0] since_rel;
  logic       armed;

  always_ff @(posedge clk_fr or posedge aclr or posedge apre) begin
    if (aclr || apre)           since_rel <= 3'd0;
    else if (since_rel != 3'd7) since_rel <= since_rel + 3'd1;
  end
  assign armed = (since_rel >= 3'd4);

  // R2: single register shows the pad value of the previous rising edge
  p_single_reg_r2: assert property (@(posedge clk_fr) disable iff (aclr || apre)
    (armed && mode == 2'd1) |=> dout[0] == $past(pad_in));

  // R3: rise bit of the DDR pair is two rising edges old
  p_ddr_rise_r3: assert property (@(posedge clk_fr) disable iff (aclr || apre)
    (armed && mode == 2'd2) |=> dout[0] == $past(pad_in, 2));

  // R4: half-rate word does not move across a non-loading full-rate period
  p_hr_hold_r4: assert property (@(posedge clk_fr) disable iff (aclr || apre)
    (armed && mode == 2'd3 && !clk_hr) |-> $stable(dout));

  // R1, R2, R3: lanes outside the mode's width stay at zero
  p_unused_lanes_r1: assert property (@(posedge clk_fr) disable iff (aclr)
    (dout & ~OUT_W'((33'd1 << live_lanes(mode, PAIRS)) - 33'd1)) == '0);

  // R5, R7: held clear empties every capture lane
  p_clear_r5: assert property (@(posedge clk_fr) disable iff (!aclr)
    (mode != 2'd0 && $past(aclr)) |-> dout == '0);

  // R6: held preset fills the half-rate word
  p_preset_r6: assert property (@(posedge clk_fr) disable iff (aclr)
    ($past(apre) && apre && !$past(aclr) && mode == 2'd3) |-> dout == '1);

  // R8: mode only moves while clear is held
  p_mode_static_r8: assert property (@(posedge clk_fr) disable iff (aclr)
    !$past(aclr) |-> $stable(mode));

  // R9: bypass follows the pad whatever clear and preset do
  p_bypass_r9: assert property (@(posedge clk_fr)
    disable iff (mode != 2'd0) dout[0] == pad_in);

endmodule

bind ddr_capture_path ddrcap_chk #(.PAIRS(PAIRS)) u_chk (
  .clk_fr (clk_fr),
  .clk_hr (clk_hr),
  .aclr   (aclr),
  .apre   (apre),
  .mode   (mode),
  .pad_in (pad_in),
  .dout   (dout)
);

// File: tb/ddr_capture_path_tb_top.sv
module ddr_capture_path_tb_top;

  logic       clk_fr, clk_hr, aclr, apre, pad_in;
  logic [1:0] mode;
  logic [3:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ddr_capture_path #(.PAIRS(2)) dut_i (
    .clk_fr (clk_fr), .clk_hr (clk_hr), .aclr (aclr), .apre (apre),
    .mode (mode), .pad_in (pad_in), .dout (dout)
  );

  // 50 MHz full-rate clock; half-rate clock toggles at each full-rate rise.
  initial begin
    clk_fr = 0; clk_hr = 0;
    forever begin
      #10; clk_hr = ~clk_hr; clk_fr = 1;
      #10; clk_fr = 0;
    end
  end

  // Behavioural sample history
  logic rs [0:8191];
  logic fs [0:8191];
  int   k   = 0;
  int   rel = 0;
  logic [3:0] hr_exp;
  bit   hr_ok = 0;
  int   pat = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic toggle = 0;

  task automatic next_bit(output logic b);
    case (pat)
      0: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; b = lfsr[0]; end
      1: begin toggle = ~toggle; b = toggle; end
      2: b = 1'b1;
      default: b = 1'b0;
    endcase
  endtask

  task automatic judge(input string tag, input logic [3:0] exp);
    checks++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d mode %0d: got %h expected %h", tag, k, mode, dout, exp);
    end
  endtask

  // One full-rate period, entered at a rising edge.
  task automatic cyc();
    logic b;
    logic [3:0] mk;
    rs[k] = pad_in;
    if (aclr || apre) hr_ok = 0;
    else if (mode == 2'd3 && clk_hr) begin
      if (k >= rel + 6) begin
        hr_exp = {fs[k-2], rs[k-2], fs[k-3], rs[k-3]};
        hr_ok = 1;
      end else hr_ok = 0;
    end
    #3;
    mk = (mode == 2'd3) ? 4'hF : (mode == 2'd2) ? 4'h3 : 4'h1;
    if (mode == 2'd0) begin
      if (aclr || apre) judge("R9", {3'b0, pad_in});
      else              judge("R1", {3'b0, pad_in});
    end else if (aclr && apre) judge("R7", 4'h0);
    else if (aclr)             judge("R5/R8", 4'h0);
    else if (apre)             judge("R6", mk);
    else if (mode == 2'd1 && k >= rel + 1) judge("R2", {3'b0, rs[k]});
    else if (mode == 2'd2 && k >= rel + 3) judge("R3", {2'b0, fs[k-1], rs[k-1]});
    else if (mode == 2'd3 && hr_ok)        judge("R4", hr_exp);
    #2; next_bit(b); pad_in = b;
    @(negedge clk_fr); fs[k] = pad_in;
    #5; next_bit(b); pad_in = b;
    @(posedge clk_fr);
    k++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // R8: mode is switched only under clear, then clear is released.
  task automatic enter_mode(input logic [1:0] m);
    aclr = 1;
    run(1);
    mode = m;
    run(2);
    aclr = 0;
    rel = k;
  endtask

  initial begin
    aclr = 1; apre = 0; mode = 2'd3; pad_in = 0;
    @(posedge clk_fr);
    run(3);                       // reset state, R5
    for (int m = 0; m < 4; m++) begin
      enter_mode(m[1:0]);
      for (int p = 0; p < 4; p++) begin
        pat = p;
        run(30);
      end
      pat = 0;
      apre = 1; run(3);           // R6 (R9 in bypass)
      aclr = 1; run(2);           // R7
      aclr = 0; apre = 0; rel = k;
      run(12);
    end
    // Clear lands on a coincident half-rate load edge in mode 3
    enter_mode(2'd3);
    run(20);
    if (clk_hr !== 1'b1) run(1);
    aclr = 1;                     // R5 at the same instant as an R4 load
    run(1);
    run(2);
    aclr = 0; rel = k;
    run(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", k);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule